// File: doc/BRIEF.md
# Round-Robin Thread Program Counter Sequencer

This block keeps a 10-bit program counter for each of four hardware threads that share one four-stage pipeline. A slot counter moves forward by one every clock, so each thread owns one cycle in every four. During that cycle the thread is in its branch stage. The caller presents the thread's 3-bit branch opcode together with three candidate targets: an absolute immediate, the top of the return stack, and the arithmetic result. The block then chooses that thread's next program counter.

The chosen address goes into the thread's PC register and into a registered fetch port, which is tagged with the thread number. The sequential increment for a thread is computed one cycle before the thread's slot, so the selection in the slot itself is only a multiplexer. The increment changes only the low 8 bits, so sequential flow wraps inside a 256-word page.

Top module: `thread_pc_sequencer`

## Requirements
- R1: After a synchronous active-high reset, every thread PC is 0, `branchId` is 0, `fetchAddr` is 0 and `fetchId` is 0.
- R2: `branchId` advances by one modulo 4 on every clock after reset. On each clock, `fetchId` takes the `branchId` value of the previous cycle, and `fetchAddr` becomes valid on the same edge.
- R3: Opcode 000 (sequential) selects the thread PC with bits 7:0 incremented modulo 256 and bits 9:8 unchanged. For example, 0x0FF becomes 0x000 and 0x3FF becomes 0x300.
- R4: Opcode 001 selects `immTarget` as the next PC.
- R5: Opcode 010 selects bits 9:0 of `stackTop` as the next PC.
- R6: Opcode 011 selects bits 9:0 of `aluResult` as the next PC.
- R7: Opcode 100 selects `immTarget` when `aluResult` bit 39 is 1. Otherwise it selects the sequential address of R3.
- R8: Opcode 101 selects bits 9:0 of `aluResult` when `aluResult` bit 39 is 1. Otherwise it selects the sequential address of R3.
- R9: A thread's PC is written only in the cycle where `branchId` equals its number. The other threads' PCs keep their values.
- R10: Opcodes 110 and 111 behave as sequential (R3), regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brOp | input | 3 | Branch opcode of the thread in its branch stage |
| immTarget | input | 10 | Absolute immediate target |
| stackTop | input | 16 | Return-stack top; the low 10 bits are used |
| aluResult | input | 40 | Arithmetic result; the low 10 bits form a target, bit 39 is the sign |
| branchId | output | 2 | Thread whose branch inputs are taken this cycle |
| fetchAddr | output | 10 | Registered next PC of the thread just resolved |
| fetchId | output | 2 | Thread that `fetchAddr` belongs to |

## Verification
Two things happen in the same cycle. The slot thread's PC is written, and the increment for the following thread is precomputed from that thread's stored PC. The bench exercises this overlap by sending every opcode with both sign values through consecutive slots, so taken jumps and sequential steps follow each other across neighbouring threads. It also drives each thread to a page-end address with bits 7:0 at 0xFF and then steps all four threads sequentially. Every fetch address is compared with a per-thread model kept in the bench. A wrong increment, a write to the wrong thread, or a missing page wrap shows up as a mismatch.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int THREAD_CNT = 4;
  localparam int SLOT_W = $clog2(THREAD_CNT);

  localparam logic [2:0] OP_SEQ     = 3'b000;
  localparam logic [2:0] OP_IMM     = 3'b001;
  localparam logic [2:0] OP_RET     = 3'b010;
  localparam logic [2:0] OP_RES     = 3'b011;
  localparam logic [2:0] OP_NEG_IMM = 3'b100;
  localparam logic [2:0] OP_NEG_RES = 3'b101;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic useInc;
    logic useImm;
    logic useStack;
    logic useResult;
  } ctlStrobes_t;
endpackage

// File: rtl/pc_seq_control.sv
module pc_seq_control
  import pc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  brOp,
  input  logic        resultNeg,
  output ctlStrobes_t strobes
);
  logic [SLOT_W-1:0] slotId;

  always_ff @(posedge clk) begin
    if (rst) slotId <= '0;
    else     slotId <= slotId + 1'b1;
  end

  always_comb begin
    strobes = '0;
    strobes.slot = slotId;
    case (brOp)
      OP_IMM:     strobes.useImm = 1'b1;
      OP_RET:     strobes.useStack = 1'b1;
      OP_RES:     strobes.useResult = 1'b1;
      OP_NEG_IMM: if (resultNeg) strobes.useImm = 1'b1; else strobes.useInc = 1'b1;
      OP_NEG_RES: if (resultNeg) strobes.useResult = 1'b1; else strobes.useInc = 1'b1;
      default:    strobes.useInc = 1'b1;
    endcase
  end

  assert_slot_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> slotId == $past(slotId) + 1'b1);

  assert_one_source_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.useInc, strobes.useImm, strobes.useStack, strobes.useResult}) == 1);

  assert_cond_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (brOp == OP_NEG_IMM && !resultNeg) |-> strobes.useInc);

  assert_cond_take_R8: assert property (@(posedge clk) disable iff (rst)
    (brOp == OP_NEG_RES && resultNeg) |-> strobes.useResult);

  assert_spare_seq_R10: assert property (@(posedge clk) disable iff (rst)
    (brOp[2:1] == 2'b11) |-> strobes.useInc);
endmodule

// File: rtl/pc_seq_datapath.sv
module pc_seq_datapath
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int INC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [PC_W-1:0]   immTarget,
  input  logic [PC_W-1:0]   stackPc,
  input  logic [PC_W-1:0]   resultPc,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [SLOT_W-1:0] fetchId
);
  localparam int PAGE_W = PC_W - INC_W;

  logic [PC_W-1:0] pcRegs [THREAD_CNT];
  logic [PC_W-1:0] incPc;
  logic [PC_W-1:0] nextPc;
  logic [PC_W-1:0] aheadPc;
  logic [SLOT_W-1:0] aheadSlot;

  assign aheadSlot = strobes.slot + 1'b1;
  assign aheadPc   = pcRegs[aheadSlot];

  // Increment for the thread whose slot comes next; only the low page bits count.
  always_ff @(posedge clk) begin
    if (rst) incPc <= PC_W'(1);
    else     incPc <= {aheadPc[PC_W-1:INC_W],
                       aheadPc[INC_W-1:0] + {{(INC_W-1){1'b0}}, 1'b1}};
  end

  always_comb begin
    nextPc = incPc;
    if (strobes.useImm)    nextPc = immTarget;
    if (strobes.useStack)  nextPc = stackPc;
    if (strobes.useResult) nextPc = resultPc;
  end

  for (genvar t = 0; t < THREAD_CNT; t++) begin : g_thread
    always_ff @(posedge clk) begin
      if (rst) pcRegs[t] <= '0;
      else if (strobes.slot == SLOT_W'(t)) pcRegs[t] <= nextPc;
    end

    assert_hold_other_R9: assert property (@(posedge clk) disable iff (rst)
      (strobes.slot != SLOT_W'(t)) |=> pcRegs[t] == $past(pcRegs[t]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchAddr <= '0;
      fetchId   <= '0;
    end else begin
      fetchAddr <= nextPc;
      fetchId   <= strobes.slot;
    end
  end

  assert_page_keep_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.useInc |=> fetchAddr[PC_W-1:INC_W] == $past(pcRegs[strobes.slot][PC_W-1:INC_W]));

  assert_imm_pick_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.useImm |=> fetchAddr == $past(immTarget));

  assert_stack_pick_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.useStack |=> fetchAddr == $past(stackPc));

  assert_result_pick_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.useResult |=> fetchAddr == $past(resultPc));

  initial assert (PAGE_W >= 0);
endmodule

// File: rtl/thread_pc_sequencer.sv
module thread_pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int INC_W = 8,
  parameter int RS_W  = 16,
  parameter int RES_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        brOp,
  input  logic [PC_W-1:0]   immTarget,
  input  logic [RS_W-1:0]   stackTop,
  input  logic [RES_W-1:0]  aluResult,
  output logic [SLOT_W-1:0] branchId,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [SLOT_W-1:0] fetchId
);
  ctlStrobes_t strobes;

  pc_seq_control u_control (
    .clk       (clk),
    .rst       (rst),
    .brOp      (brOp),
    .resultNeg (aluResult[RES_W-1]),
    .strobes   (strobes)
  );

  pc_seq_datapath #(.PC_W(PC_W), .INC_W(INC_W)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .immTarget (immTarget),
    .stackPc   (stackTop[PC_W-1:0]),
    .resultPc  (aluResult[PC_W-1:0]),
    .fetchAddr (fetchAddr),
    .fetchId   (fetchId)
  );

  assign branchId = strobes.slot;

  assert_fetch_tag_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> fetchId == $past(branchId));
endmodule

// File: tb/thread_pc_sequencer_bench.sv
module thread_pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  brOp = '0;
  logic [9:0]  immTarget = '0;
  logic [15:0] stackTop = '0;
  logic [39:0] aluResult = '0;
  logic [1:0]  branchId;
  logic [9:0]  fetchAddr;
  logic [1:0]  fetchId;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  logic [9:0] model [4];
  int slot = 0;

  always #5 clk = ~clk;

  thread_pc_sequencer u_thread_pc_sequencer (
    .clk(clk), .rst(rst), .brOp(brOp), .immTarget(immTarget),
    .stackTop(stackTop), .aluResult(aluResult),
    .branchId(branchId), .fetchAddr(fetchAddr), .fetchId(fetchId)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsFailed++;
      $display("FAIL R2 watchdog actual=%0d expected<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] seqOf(input logic [9:0] pc);
    return {pc[9:8], 8'(pc[7:0] + 8'd1)};
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Called at a negative edge; leaves at the following negative edge.
  task automatic step(input logic [2:0] op, input logic [9:0] imm,
                      input logic [15:0] stk, input logic [39:0] res, input string tag);
    logic [9:0] exp;
    logic [9:0] cur;
    string req;
    cur = model[slot];
    case (op)
      3'd1: exp = imm;
      3'd2: exp = stk[9:0];
      3'd3: exp = res[9:0];
      3'd4: exp = res[39] ? imm : seqOf(cur);
      3'd5: exp = res[39] ? res[9:0] : seqOf(cur);
      default: exp = seqOf(cur);
    endcase
    req = (tag.len() != 0) ? tag : tagOf(op);
    check("R2 branchId", int'(branchId), slot);
    brOp = op; immTarget = imm; stackTop = stk; aluResult = res;
    @(posedge clk);
    @(negedge clk);
    check("R2 fetchId", int'(fetchId), slot);
    check(req, int'(fetchAddr), int'(exp));
    model[slot] = exp;
    slot = (slot + 1) % 4;
  endtask

  initial begin
    for (int t = 0; t < 4; t++) model[t] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible before any slot completes
    check("R1 fetchAddr", int'(fetchAddr), 0);
    check("R1 fetchId", int'(fetchId), 0);
    check("R1 branchId", int'(branchId), 0);

    // Sweep every opcode with both signs, several passes with varied data.
    for (int pass = 0; pass < 6; pass++) begin
      for (int op = 0; op < 8; op++) begin
        for (int sg = 0; sg < 2; sg++) begin
          int n;
          n = pass * 16 + op * 2 + sg;
          step(3'(op), 10'((n * 37 + 5) & 1023),
               16'((n * 4099 + 3) & 65535),
               {1'(sg), 29'(n * 7919), 10'((n * 53 + 9) & 1023)}, "");
        end
      end
    end

    // R3: page-end wrap for every thread, bits 9:8 kept
    for (int t = 0; t < 4; t++)
      step(3'd1, {2'(t), 8'hFF}, 16'h0, 40'h0, "R4");
    for (int t = 0; t < 4; t++)
      step(3'd0, 10'h155, 16'hFFFF, 40'hFF_FFFF_FFFF, "R3 wrap");

    // R9: mixed jumps on some threads, then sequential on all; each keeps its own history
    step(3'd1, 10'h2A0, 16'h0, 40'h0, "R4");
    step(3'd0, 10'h3FF, 16'h0, 40'h0, "R9");
    step(3'd3, 10'h000, 16'h0, 40'h00_0000_0133, "R6");
    step(3'd0, 10'h000, 16'h0, 40'h0, "R9");
    for (int k = 0; k < 8; k++)
      step(3'd0, 10'h3FF, 16'h3FF, 40'h80_0000_03FF, "R9");

    // R10: spare codes ignore the candidates even when the sign is set
    for (int k = 0; k < 4; k++)
      step(3'd6 + 3'(k & 1), 10'h3C3, 16'h0222, 40'h80_0000_0111, "R10");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule